// File: doc/BRIEF.md
# Smart Card Elementary Time Unit Generator

This block turns the system clock into the timing reference of a smart card serial channel. A prescaler divides the system clock by a power of four chosen by a two-bit select, and an eight-bit divisor further divides the resulting ticks. Each divided tick is one half period of the card clock. An elementary time unit (one transmitted or received bit) spans 744 such half periods, so exactly 372 card clock cycles fit in every bit.

The generator gives a one-cycle strobe at each bit boundary and a one-cycle strobe in the middle of each bit, where a receiver would sample the line. It can also drive the card clock pin. The timing source is always internal. The select and divisor are captured only while the generator is disabled. Changes made while it runs take effect at the next enable.

With select n and divisor N, a bit lasts 744 × 4^n × (N+1) system clocks, and the card clock has a period of 2 × 4^n × (N+1) system clocks.

Top module: `sc_etu_gen`

## Requirements
- R1: While `rst_n` is low, or on any cycle after a clock edge at which `enable` was low, `bit_strobe`, `sample_strobe` and `sck` are all 0.
- R2: `clk_sel` picks the prescale factor: 0 gives 1, 1 gives 4, 2 gives 16 and 3 gives 64 system clocks per tick.
- R3: `divisor` N (0 to 255) makes each card clock half period last N+1 prescaled ticks. The first rising edge of `sck` follows 4^n × (N+1) rising clock edges counted from the first edge that samples `enable` high, and the first falling edge follows twice that number.
- R4: The first `bit_strobe` goes high after 744 × 4^n × (N+1) edges counted from the first edge that samples `enable` high. It then repeats with that same period and is one cycle wide.
- R5: `sample_strobe` goes high after 372 × 4^n × (N+1) edges counted from the start of each bit, and is one cycle wide.
- R6: Between two successive `bit_strobe` pulses, `sck` rises exactly 372 times, and it is low on a cycle that carries either strobe.
- R7: When `sck_out_en` is low, `sck` stays 0 and the strobe timing is unchanged.
- R8: Changes to `clk_sel` or `divisor` while `enable` is high have no effect. The values present while `enable` is low are used at the next enable.
- R9: Lowering `enable` clears all counters. A new enable restarts the first bit from zero.
- R10: `bit_strobe` and `sample_strobe` are never high on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run control; low clears the counters and loads the configuration |
| clk_sel | input | 2 | Prescale select (factor 4^clk_sel) |
| divisor | input | 8 | Divisor N; half period of the card clock is N+1 ticks |
| sck_out_en | input | 1 | Lets the card clock reach the `sck` pin |
| bit_strobe | output | 1 | One-cycle pulse at each bit boundary |
| sample_strobe | output | 1 | One-cycle pulse at mid-bit |
| sck | output | 1 | Card clock, 372 cycles per bit |

## Verification
The bench measures the exact edge count to the first card clock edge and to both strobes for every prescale select, and for divisors 0, 3 and 255. An off-by-one reload in the prescaler or the divisor would show up here as a period short or long by one tick per half period. It counts card clock rises over a full bit, which catches a bit counter that wraps at 743 or 745. It changes the configuration in mid-run, where a generator that reads live inputs would change its rate. It also drops and re-raises the enable mid-bit, where a generator that kept stale counts would strobe early.

// File: rtl/sc_etu_pkg.sv
package sc_etu_pkg;

    typedef enum logic [1:0] {
        PS_DIV1  = 2'd0,
        PS_DIV4  = 2'd1,
        PS_DIV16 = 2'd2,
        PS_DIV64 = 2'd3
    } presc_sel_e;

    localparam int unsigned SEL_W = $bits(presc_sel_e);

    // half periods of the card clock in one elementary time unit
    localparam int unsigned ETU_HALVES_DEFAULT = 744;

endpackage

// File: rtl/sc_etu_prescaler.sv
module sc_etu_prescaler #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned NSEL  = 1 << SEL_W;
    localparam int unsigned PRE_W = (2 * (NSEL - 1) > 0) ? 2 * (NSEL - 1) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] lim_tbl [NSEL];

    // terminal count for each select: 4^g - 1
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_tbl[g] = PRE_W'((1 << (2 * g)) - 1);
    end

    assign tick = run && (st_q.cnt == lim_tbl[sel]);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sc_etu_divider.sv
module sc_etu_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] limit,
    output logic             half_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    assign half_tick = run && tick && (st_q.cnt == limit);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == limit) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sc_etu_bitcnt.sv
module sc_etu_bitcnt #(
    parameter int unsigned ETU_HALVES = 744
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic half_tick,
    output logic bit_stb,
    output logic smp_stb,
    output logic phase
);
    localparam int unsigned CNT_W   = $clog2(ETU_HALVES);
    localparam int unsigned MID_AT  = ETU_HALVES / 2;
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(ETU_HALVES - 1);
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(MID_AT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic             bit_stb;
        logic             smp_stb;
    } bc_st_t;

    bc_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.bit_stb = 1'b0;
        st_d.smp_stb = 1'b0;
        if (!run) begin
            st_d = '0;
        end else if (half_tick) begin
            st_d.phase = ~st_q.phase;
            if (st_q.cnt == LAST_C) begin
                st_d.cnt     = '0;
                st_d.bit_stb = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt == MID_C) begin
                st_d.smp_stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_stb = st_q.bit_stb;
    assign smp_stb = st_q.smp_stb;
    assign phase   = st_q.phase;

endmodule

// File: rtl/sc_etu_gen.sv
module sc_etu_gen
    import sc_etu_pkg::*;
#(
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned ETU_HALVES = ETU_HALVES_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       clk_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             sck_out_en,
    output logic             bit_strobe,
    output logic             sample_strobe,
    output logic             sck
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic pre_tick;
    logic half_tick;
    logic sck_phase;

    // configuration follows the inputs only while stopped
    always_comb begin
        cfg_d = cfg_q;
        if (!enable) begin
            cfg_d.sel = clk_sel;
            cfg_d.div = divisor;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    sc_etu_prescaler #(
        .SEL_W (SEL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .sel   (cfg_q.sel),
        .tick  (pre_tick)
    );

    sc_etu_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .tick      (pre_tick),
        .limit     (cfg_q.div),
        .half_tick (half_tick)
    );

    sc_etu_bitcnt #(
        .ETU_HALVES (ETU_HALVES)
    ) u_bit (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .half_tick (half_tick),
        .bit_stb   (bit_strobe),
        .smp_stb   (sample_strobe),
        .phase     (sck_phase)
    );

    assign sck = sck_phase & sck_out_en;

endmodule

// File: rtl/sc_etu_gen_chk.sv
module sc_etu_gen_chk #(
    parameter int unsigned ETU_HALVES = 744
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic bit_strobe,
    input logic sample_strobe,
    input logic sck,
    input logic sck_phase,
    input logic half_tick
);
    localparam int unsigned HC_W = $clog2(ETU_HALVES + 1) + 1;

    logic [HC_W-1:0] halves_q;

    // half periods seen since the last bit boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halves_q <= '0;
        end else if (!enable) begin
            halves_q <= '0;
        end else if (bit_strobe) begin
            halves_q <= HC_W'(half_tick);
        end else begin
            halves_q <= halves_q + HC_W'(half_tick);
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bit_strobe && !sample_strobe && !sck));

    p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !half_tick) |=> $stable(sck_phase));

    p_bit_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe);

    p_etu_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (halves_q == HC_W'(ETU_HALVES)));

    p_smp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    p_phase_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe || sample_strobe) |-> !sck_phase);

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_strobe && sample_strobe));

endmodule

bind sc_etu_gen sc_etu_gen_chk #(
    .ETU_HALVES (ETU_HALVES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .bit_strobe    (bit_strobe),
    .sample_strobe (sample_strobe),
    .sck           (sck),
    .sck_phase     (sck_phase),
    .half_tick     (half_tick)
);

// File: tb/test_sc_etu_gen.sv
module test_sc_etu_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, en2 = 1'b0;
    logic [1:0] sel = 2'd0, sel2 = 2'd0;
    logic [7:0] dv = 8'd0, dv2 = 8'd0;
    logic       oe = 1'b1;
    logic       bstb, sstb, sck;
    logic       bstb2, sstb2, sck2;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int overlap = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if ((bstb && sstb) || (bstb2 && sstb2)) overlap++;

    sc_etu_gen i_sc_etu_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (en),
        .clk_sel       (sel),
        .divisor       (dv),
        .sck_out_en    (oe),
        .bit_strobe    (bstb),
        .sample_strobe (sstb),
        .sck           (sck)
    );

    // short bit length so the largest divisor fits the run budget
    sc_etu_gen #(.ETU_HALVES(4)) i_sc_etu_gen_short (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (en2),
        .clk_sel       (sel2),
        .divisor       (dv2),
        .sck_out_en    (1'b1),
        .bit_strobe    (bstb2),
        .sample_strobe (sstb2),
        .sck           (sck2)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_a(input logic [1:0] s, input logic [7:0] n, output int t0);
        @(negedge clk);
        en = 1'b0; sel = s; dv = n;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        t0 = cyc;
    endtask

    task automatic wait_bit_a(output int at);
        do @(negedge clk); while (!bstb);
        at = cyc;
    endtask

    task automatic t_reset();
        check(!bstb && !sstb && !sck, "R1", "outputs in reset", {bstb, sstb, sck}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!bstb && !sstb && !sck, "R1", "outputs while disabled", {bstb, sstb, sck}, 0);
    endtask

    // R2 R3 R4 R5 R6: full timing for one select/divisor pair
    task automatic t_rate(input logic [1:0] s, input logic [7:0] n, input bit two);
        int t0, t1, t2, rises;
        longint unit;
        logic prev;
        unit = longint'(1 << (2 * s)) * (n + 1);
        start_a(s, n, t0);
        do @(negedge clk); while (!sck);
        check(cyc - t0 == unit, "R3", "first sck rise", cyc - t0, unit);
        do @(negedge clk); while (!sstb);
        check(cyc - t0 == 372 * unit, "R5", "sample strobe", cyc - t0, 372 * unit);
        wait_bit_a(t1);
        check(t1 - t0 == 744 * unit, "R2", "first bit strobe", t1 - t0, 744 * unit);
        check(!sck, "R6", "sck low on strobe", sck, 0);
        if (two) begin
            rises = 0;
            prev = sck;
            do begin
                @(negedge clk);
                if (sck && !prev) rises++;
                prev = sck;
            end while (!bstb);
            t2 = cyc;
            check(t2 - t1 == 744 * unit, "R4", "bit period", t2 - t1, 744 * unit);
            check(rises == 372, "R6", "sck rises per bit", rises, 372);
        end
        en = 1'b0;
    endtask

    task automatic t_sck_half(input logic [1:0] s, input logic [7:0] n);
        int t0;
        longint unit;
        unit = longint'(1 << (2 * s)) * (n + 1);
        start_a(s, n, t0);
        do @(negedge clk); while (!sck);
        check(cyc - t0 == unit, "R3", "sck rise, max divisor", cyc - t0, unit);
        do @(negedge clk); while (sck);
        check(cyc - t0 == 2 * unit, "R3", "sck fall, max divisor", cyc - t0, 2 * unit);
        en = 1'b0;
    endtask

    task automatic t_oe_off();
        int t0, t1, highs;
        highs = 0;
        oe = 1'b0;
        start_a(2'd0, 8'd0, t0);
        do begin
            @(negedge clk);
            if (sck) highs++;
        end while (!bstb);
        t1 = cyc;
        check(highs == 0, "R7", "sck held low", highs, 0);
        check(t1 - t0 == 744, "R7", "strobe timing with output off", t1 - t0, 744);
        en = 1'b0;
        oe = 1'b1;
    endtask

    task automatic t_cfg_hold();
        int t0, t1, t2;
        start_a(2'd0, 8'd0, t0);
        repeat (100) @(negedge clk);
        sel = 2'd3; dv = 8'd9;
        wait_bit_a(t1);
        check(t1 - t0 == 744, "R8", "first bit after live change", t1 - t0, 744);
        wait_bit_a(t2);
        check(t2 - t1 == 744, "R8", "period after live change", t2 - t1, 744);
        start_a(2'd0, 8'd1, t0);
        do @(negedge clk); while (!sck);
        check(cyc - t0 == 2, "R8", "new divisor after re-enable", cyc - t0, 2);
        en = 1'b0;
    endtask

    task automatic t_restart();
        int t0, t1;
        start_a(2'd0, 8'd0, t0);
        repeat (500) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!bstb && !sstb && !sck, "R9", "cleared on disable", {bstb, sstb, sck}, 0);
        repeat (3) @(negedge clk);
        en = 1'b1;
        t0 = cyc;
        wait_bit_a(t1);
        check(t1 - t0 == 744, "R9", "first bit after restart", t1 - t0, 744);
        en = 1'b0;
    endtask

    task automatic t_short(input logic [1:0] s);
        int t0, t1, t2;
        longint unit;
        unit = longint'(1 << (2 * s)) * 256;
        @(negedge clk);
        en2 = 1'b0; sel2 = s; dv2 = 8'd255;
        @(negedge clk);
        en2 = 1'b1;
        t0 = cyc;
        do @(negedge clk); while (!bstb2);
        t1 = cyc;
        check(t1 - t0 == 4 * unit, "R4", "short bit, divisor 255", t1 - t0, 4 * unit);
        do @(negedge clk); while (!bstb2);
        t2 = cyc;
        check(t2 - t1 == 4 * unit, "R4", "short period, divisor 255", t2 - t1, 4 * unit);
        en2 = 1'b0;
    endtask

    initial begin
        wait (cyc > WDOG);
        check(1'b0, "WDOG", "watchdog expired", cyc, WDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rate(2'd0, 8'd0, 1'b1);
        t_rate(2'd1, 8'd0, 1'b1);
        t_rate(2'd2, 8'd0, 1'b1);
        t_rate(2'd3, 8'd0, 1'b0);
        t_rate(2'd0, 8'd3, 1'b1);
        t_sck_half(2'd0, 8'd255);
        t_sck_half(2'd3, 8'd255);
        t_oe_off();
        t_cfg_hold();
        t_restart();
        t_short(2'd0);
        t_short(2'd1);
        check(overlap == 0, "R10", "strobe overlap cycles", overlap, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule